// File: doc/BRIEF.md
# Six-Button Gamepad Port Multiplexer

This block models the read side of a game controller port. The port has eight pins. Bit 6 of the port data register is a select line that the host drives. The host toggles it to choose which group of buttons shows up on the low six pins. The block takes the pressed state of twelve buttons, the port data register and the port direction register. It returns the eight-bit value the host sees when it reads the port.

A small phase counter watches the select line. In six-button mode, the third and fourth passes through the select cycle expose an identification pattern and then the four extra buttons on the same pins. If the select line stops toggling for a programmable number of clock cycles, the counter falls back to its start. That default equals 1.5 ms at 250 MHz. With six-button mode off, the port behaves as a plain three-button pad.

Top module: `pad_port_mux`

## Requirements
- R1: `btn_pressed` is active-high. Bit order is [11]=M, [10]=X, [9]=Y, [8]=Z, [7]=Start, [6]=A, [5]=C, [4]=B, [3]=Right, [2]=Left, [1]=Down, [0]=Up. On the port a pressed button reads as 0 and a released one as 1.
- R2: Any bit set in `port_dir`, and bit 7 always, reads from `port_data`. The other bits carry button data. Bits 7 and 6 receive no button data, so they read 0 when they are not taken from `port_data`.
- R3: With the select line (`port_data[6]`) high and no six-button case active, bits 5..0 read C, B, Right, Left, Down, Up.
- R4: With the select line low and no six-button case active, bits 5..4 read Start, A; bits 3..2 read 0; bits 1..0 read Down, Up.
- R5: In six-button mode at phase 2 with the select line low, bits 5..4 read Start, A and bits 3..0 read 0000.
- R6: In six-button mode at phase 3 with the select line high, bits 5..4 read C, B and bits 3..0 read M, X, Y, Z.
- R7: In six-button mode at phase 3 with the select line low, bits 5..4 read Start, A and bits 3..0 read 1111.
- R8: With `six_btn_en` low, only R3 and R4 apply, whatever the phase. In six-button mode, phases 0 and 1 also follow R3 and R4.
- R9: The phase increases by one at each clock edge that first sees the select line high after it was low, and stays at 3 once it gets there. A falling select line leaves the phase unchanged.
- R10: If the select line does not change for TIMEOUT_CYCLES clock edges after its last change, the phase returns to 0.
- R11: Reset sets the phase to 0. After reset the select line is taken as high, so holding it high does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| six_btn_en | input | 1 | Enables the six-button phase sequence |
| btn_pressed | input | 12 | Button states, 1 = pressed |
| port_data | input | 8 | Port data register; bit 6 is the select line |
| port_dir | input | 8 | Port direction register; 1 = output bit |
| rd_value | output | 8 | Value returned on a port read |

## Verification
The assertions assume that every input is known from the first clock after reset. They also assume the select line is sampled on the clock, so a pulse shorter than one cycle is never seen. The bench keeps within this by setting every input during reset. It changes inputs only on falling clock edges, and at most one select-line transition per cycle. Read values are checked once the rising edge has updated the phase.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  localparam int BTN_W   = 12;
  localparam int PORT_W  = 8;
  localparam int FIELD_W = 6;
  localparam int SEL_BIT = 6;

  // button positions inside the button vector
  localparam int B_UP = 0, B_DOWN = 1, B_LEFT = 2, B_RIGHT = 3;
  localparam int B_B = 4, B_C = 5, B_A = 6, B_START = 7;
  localparam int B_Z = 8, B_Y = 9, B_X = 10, B_M = 11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_ID   = 2'd2,
    PH_EXT  = 2'd3
  } pad_phase_e;

  // Pin levels for the low six bits; lvl is already active-low.
  function automatic logic [FIELD_W-1:0] pad_field(
    input logic [BTN_W-1:0] lvl,
    input logic             sel,
    input pad_phase_e       ph,
    input logic             six);
    logic [FIELD_W-1:0] f;
    if (six && ph == PH_EXT && sel)
      f = {lvl[B_C], lvl[B_B], lvl[B_M], lvl[B_X], lvl[B_Y], lvl[B_Z]};
    else if (six && ph == PH_EXT)
      f = {lvl[B_START], lvl[B_A], 4'b1111};
    else if (six && ph == PH_ID && !sel)
      f = {lvl[B_START], lvl[B_A], 4'b0000};
    else if (sel)
      f = {lvl[B_C], lvl[B_B], lvl[B_RIGHT], lvl[B_LEFT], lvl[B_DOWN], lvl[B_UP]};
    else
      f = {lvl[B_START], lvl[B_A], 2'b00, lvl[B_DOWN], lvl[B_UP]};
    return f;
  endfunction

  function automatic logic [PORT_W-1:0] port_keep_mask(input logic [PORT_W-1:0] dir);
    logic [PORT_W-1:0] m;
    m = dir;
    m[PORT_W-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [PORT_W-1:0] port_merge(
    input logic [PORT_W-1:0]  data,
    input logic [PORT_W-1:0]  keep,
    input logic [FIELD_W-1:0] field);
    logic [PORT_W-1:0] wide;
    wide = {{(PORT_W-FIELD_W){1'b0}}, field};
    return (data & keep) | (wide & ~keep);
  endfunction
endpackage

// File: rtl/pad_phase_track.sv
module pad_phase_track
  import pad_port_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 375000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  output pad_phase_e phase,
  output logic       th_rise,
  output logic       th_toggle,
  output logic       idle_expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] IDLE_LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             sel_q;
  logic [CNT_W-1:0] idle_cnt;

  assign th_toggle   = sel ^ sel_q;
  assign th_rise     = sel & ~sel_q;
  assign idle_expire = !th_toggle && (idle_cnt == IDLE_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b1;
      idle_cnt <= '0;
      phase    <= PH_IDLE;
    end else begin
      sel_q <= sel;
      if (th_toggle)
        idle_cnt <= '0;
      else if (idle_cnt != IDLE_LIMIT)
        idle_cnt <= idle_cnt + 1'b1;
      if (th_rise) begin
        if (phase != PH_EXT) phase <= pad_phase_e'(phase + 2'd1);
      end else if (idle_expire) begin
        phase <= PH_IDLE;
      end
    end
  end

  AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (th_rise && phase != PH_EXT) |=> (phase == $past(phase) + 2'd1)); // R9
  AST_RISE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (th_rise && phase == PH_EXT) |=> (phase == PH_EXT)); // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!th_rise && !idle_expire) |=> $stable(phase)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    idle_expire |=> (phase == PH_IDLE)); // R10
endmodule

// File: rtl/pad_field_sel.sv
module pad_field_sel
  import pad_port_pkg::*;
(
  input  logic [BTN_W-1:0]   btn_pressed,
  input  logic               sel,
  input  pad_phase_e         phase,
  input  logic               six_btn_en,
  output logic [FIELD_W-1:0] field
);
  logic [BTN_W-1:0] btn_level;
  assign btn_level = ~btn_pressed;
  assign field = pad_field(btn_level, sel, phase, six_btn_en);
endmodule

// File: rtl/pad_port_mux.sv
module pad_port_mux
  import pad_port_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 375000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              six_btn_en,
  input  logic [BTN_W-1:0]  btn_pressed,
  input  logic [PORT_W-1:0] port_data,
  input  logic [PORT_W-1:0] port_dir,
  output logic [PORT_W-1:0] rd_value
);
  pad_phase_e         phase;
  logic               th_rise, th_toggle, idle_expire;
  logic               sel;
  logic [FIELD_W-1:0] field;
  logic [PORT_W-1:0]  keep;

  assign sel  = port_data[SEL_BIT];
  assign keep = port_keep_mask(port_dir);

  pad_phase_track #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_phase (
    .clk(clk), .rst_n(rst_n), .sel(sel), .phase(phase),
    .th_rise(th_rise), .th_toggle(th_toggle), .idle_expire(idle_expire));

  pad_field_sel u_sel (
    .btn_pressed(btn_pressed), .sel(sel), .phase(phase),
    .six_btn_en(six_btn_en), .field(field));

  assign rd_value = port_merge(port_data, keep, field);

  AST_DIR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_value & keep) == (port_data & keep))); // R2
  AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (six_btn_en && phase == PH_ID && !sel) |-> ((rd_value[3:0] & ~keep[3:0]) == 4'h0)); // R5
  AST_EXT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (six_btn_en && phase == PH_EXT && !sel) |-> ((rd_value[3:0] | keep[3:0]) == 4'hF)); // R7
endmodule

// File: tb/pad_port_mux_test.sv
module pad_port_mux_test;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        six_btn_en = 1'b0;
  logic [11:0] btn_pressed = '0;
  logic [7:0]  port_data = 8'h40;
  logic [7:0]  port_dir = 8'h40;
  logic [7:0]  rd_value;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pad_port_mux #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .six_btn_en(six_btn_en),
    .btn_pressed(btn_pressed), .port_data(port_data),
    .port_dir(port_dir), .rd_value(rd_value));

  // independent model of the read value
  function automatic logic [7:0] model(input logic [11:0] b, input logic [7:0] d,
                                       input logic [7:0] dir, input int ph, input bit six);
    logic up, dn, lf, rt, bb, cc, aa, st, zz, yy, xx, mm, th;
    logic [7:0] pins, keep;
    {mm, xx, yy, zz, st, aa, cc, bb, rt, lf, dn, up} = ~b;
    th = d[6];
    pins = 8'h00;
    if (six && ph == 3 && th)       pins[5:0] = {cc, bb, mm, xx, yy, zz};
    else if (six && ph == 3)        pins[5:0] = {st, aa, 4'hF};
    else if (six && ph == 2 && !th) pins[5:0] = {st, aa, 4'h0};
    else if (th)                    pins[5:0] = {cc, bb, rt, lf, dn, up};
    else                            pins[5:0] = {st, aa, 2'b00, dn, up};
    keep = dir | 8'h80;
    return (d & keep) | (pins & ~keep);
  endfunction

  task automatic check(input int ph, input string tag);
    logic [7:0] exp;
    exp = model(btn_pressed, port_data, port_dir, ph, six_btn_en);
    checks++;
    if (rd_value !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, rd_value, exp);
    end
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk); port_data[6] = v;
    @(posedge clk); #1;
  endtask

  task automatic set_in(input logic [11:0] b, input logic [7:0] d, input logic [7:0] dir);
    @(negedge clk); btn_pressed = b; port_data = d; port_dir = dir;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset_state;
    six_btn_en = 1'b1;
    set_in(12'h000, 8'h40, 8'h40);
    check(0, "R11 reset state, select high");
    set_sel(1'b0);
    check(0, "R11 reset phase not at id");
  endtask

  task automatic t_normal;
    six_btn_en = 1'b0;
    set_in(12'h0FF, 8'h40, 8'h40); check(0, "R1 R3 all pressed select high");
    set_in(12'h00A, 8'h40, 8'h40); check(0, "R3 right+down");
    set_in(12'h0C1, 8'h00, 8'h40); check(0, "R4 start+a+up select low");
    set_in(12'h0FC, 8'h00, 8'h40); check(0, "R4 left/right hidden");
    set_in(12'hF30, 8'h40, 8'h40); check(0, "R1 extra buttons unseen");
  endtask

  task automatic t_dir;
    six_btn_en = 1'b0;
    set_in(12'h0FF, 8'hE5, 8'h4F); check(0, "R2 low nibble from data");
    set_in(12'h000, 8'h40, 8'h00); check(0, "R2 bit6 input reads 0");
    set_in(12'h000, 8'hC0, 8'h00); check(0, "R2 bit7 always from data");
  endtask

  task automatic t_six_seq;
    six_btn_en = 1'b1;
    do_reset();
    set_in(12'h5A3, 8'h40, 8'h40);
    set_sel(1'b0); check(0, "R8 phase0 select low");
    set_sel(1'b1); check(1, "R9 R8 phase1 select high");
    set_sel(1'b0); check(1, "R9 fall keeps phase1");
    set_sel(1'b1); check(2, "R8 phase2 select high");
    set_sel(1'b0); check(2, "R5 id pattern");
    set_sel(1'b1); check(3, "R6 extra buttons");
    set_sel(1'b0); check(3, "R7 ones nibble");
    set_sel(1'b1); check(3, "R9 saturate at 3");
    set_in(12'hA5C, 8'h40, 8'h40); check(3, "R6 other buttons");
    set_sel(1'b0); check(3, "R7 after saturate");
    six_btn_en = 1'b0; #1;
    check(3, "R8 mode off at phase3 low");
    set_sel(1'b1); check(3, "R8 mode off at phase3 high");
  endtask

  task automatic t_timeout;
    six_btn_en = 1'b1;
    do_reset();
    set_sel(1'b0); set_sel(1'b1); set_sel(1'b0); set_sel(1'b1);
    set_sel(1'b0); set_sel(1'b1); set_sel(1'b0);
    check(3, "R7 before timeout");
    repeat (TMO - 2) @(posedge clk);
    #1; check(3, "R10 phase held just before limit");
    repeat (2) @(posedge clk);
    #1; check(0, "R10 phase cleared after limit");
    set_sel(1'b1); set_sel(1'b0);
    check(1, "R10 count restarts from 0");
  endtask

  task automatic t_reset_mid;
    six_btn_en = 1'b1;
    set_sel(1'b1); set_sel(1'b0); set_sel(1'b1); set_sel(1'b0);
    check(3, "R7 reached before reset");
    do_reset();
    check(0, "R11 reset clears phase");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset_state();
    t_normal();
    t_dir();
    t_six_seq();
    t_timeout();
    t_reset_mid();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule